// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Dual Compare

This block is an 8-bit up-counter that runs entirely on the system clock. It advances only on cycles where an internal prescaler raises a one-cycle enable. Two compare channels, A and B, each hold a compare value and a sticky match flag. A third sticky flag records every wrap of the counter from its maximum value to zero. Software reaches all state through a single write port, and clears flags by writing ones.

Four counting modes are available:
- **Free-running:** the counter wraps at MAX.
- **Clear-on-match:** channel A's value is the period.
- **Fast PWM, full period:** TOP is MAX.
- **Fast PWM, variable period:** TOP is channel A's value.

In both PWM modes the waveform output goes high at the start of each period and low after channel B matches. Compare values written in a PWM mode are held in a shadow register and only take effect at the start of the next period, so the duty cycle never glitches.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset the count, the compare values, the control and all three flags are zero, and the waveform output is low.
- R2: Control field `wr_data[3:2]` (address 3) picks the tick rate.
  - 0 stops the counter.
  - 1 ticks every cycle.
  - 2 ticks once per 8 cycles.
  - 3 ticks once per 64 cycles.
  - A change of this field restarts the division, so the first tick lands exactly 8 (or 64) cycles after the write edge.
- R3: Mode 0 (`wr_data[1:0]` of address 3) counts up by one per tick and wraps from 0xFF to 0x00. The wrap sets the overflow flag (`flag_o[2]`).
- R4: On a tick where the count equals channel B's compare value (address 2), `flag_o[1]` sets. This holds in every mode.
- R5: In mode 1, a tick where the count equals channel A's compare value (address 1) clears the counter to zero and sets `flag_o[0]`. No overflow is flagged.
- R6: In modes 1 and 3, overflow sets only when the count actually wraps from 0xFF. This happens, for example, after channel A's value is written below the current count.
- R7: Writing to address 4 clears each flag whose data bit is 1. A flag that is set and cleared in the same cycle stays set.
- R8: A write to the count (address 0) overrides that cycle's increment. It also masks compare matches on the next tick.
- R9: In mode 2 the waveform output rises when the counter wraps to zero and falls on the tick after a channel B match. In modes 0 and 1 it is low.
- R10: In modes 2 and 3, newly written compare values take effect only when the counter next returns to zero. Until then the old values keep governing matches.
- R11: In mode 3 the counter clears when it matches channel A. That clear sets `flag_o[0]` and raises the waveform output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 count, 1 compare A, 2 compare B, 3 control, 4 flag clear |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| flag_o | output | 3 | Sticky flags: bit 0 channel A, bit 1 channel B, bit 2 overflow |
| pwm_o | output | 1 | Fast PWM waveform |

## Verification
The properties assume that every flag clear or count load arrives through `wr_en` with a legal address, and that reset is held low across the first clock edges. The bench meets this by driving every write from a single task, which changes inputs only on the falling edge and holds each strobe for exactly one cycle. Before counting starts, each scenario stops the counter and loads the compare values, so that no PWM-mode shadow update is pending that the expected values fail to account for.

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
  parameter int CW      = 8,
  parameter int DIV_MID = 8,
  parameter int DIV_HI  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count_o,
  output logic [2:0]    flag_o,
  output logic          pwm_o
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] MID_LAST = PW'(DIV_MID - 1);
  localparam logic [PW-1:0] HI_LAST  = PW'(DIV_HI - 1);
  localparam logic [CW-1:0] MAXV     = {CW{1'b1}};
  localparam logic [2:0] A_CNT = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_CTRL = 3'd3, A_FLAG = 3'd4;

  logic [1:0]    mode_q, sel_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q, bufa_q, bufb_q, effa_q, effb_q;
  logic          supp_q, pwm_q;
  logic [2:0]    flg_q;

  wire wr_cnt  = wr_en && wr_addr == A_CNT;
  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire [2:0] clr_mask = (wr_en && wr_addr == A_FLAG) ? wr_data[2:0] : 3'b000;

  wire is_pwm = mode_q[1];
  wire top_a  = mode_q[0] && (mode_q != 2'd0);
  wire [CW-1:0] cmpa = is_pwm ? effa_q : bufa_q;
  wire [CW-1:0] cmpb = is_pwm ? effb_q : bufb_q;

  wire tick = (sel_q == 2'd1)
            | ((sel_q == 2'd2) && ((pre_q & MID_LAST) == MID_LAST))
            | ((sel_q == 2'd3) && (pre_q == HI_LAST));

  wire hit_a  = tick && !supp_q && cnt_q == cmpa;
  wire hit_b  = tick && !supp_q && cnt_q == cmpb;
  wire at_max = cnt_q == MAXV;
  wire wrap   = tick && (at_max || (top_a && hit_a));
  wire [2:0] set_v = {tick && at_max, hit_b, hit_a};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; sel_q <= '0; pre_q <= '0;
      cnt_q  <= '0; bufa_q <= '0; bufb_q <= '0; effa_q <= '0; effb_q <= '0;
      supp_q <= 1'b0; pwm_q <= 1'b0; flg_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wr_data[1:0];
        sel_q  <= wr_data[3:2];
      end
      if ((wr_ctrl && wr_data[3:2] != sel_q) || sel_q == 2'd0) pre_q <= '0;
      else pre_q <= pre_q + 1'b1;

      if (wr_en && wr_addr == A_CMPA) bufa_q <= wr_data;
      if (wr_en && wr_addr == A_CMPB) bufb_q <= wr_data;
      if (!is_pwm || wrap) begin
        effa_q <= bufa_q;
        effb_q <= bufb_q;
      end

      if (wr_cnt) begin
        cnt_q  <= wr_data;
        supp_q <= 1'b1;
      end else if (tick) begin
        cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
        supp_q <= 1'b0;
      end

      flg_q <= (flg_q & ~clr_mask) | set_v;

      if (!is_pwm)    pwm_q <= 1'b0;
      else if (wrap)  pwm_q <= 1'b1;
      else if (hit_b) pwm_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flg_q;
  assign pwm_o   = pwm_q;
endmodule

module tmr8_cmp_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count_o,
  input logic [2:0]    flag_o,
  input logic          pwm_o,
  input logic [1:0]    mode_q,
  input logic [1:0]    sel_q
);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_o) & ~flag_o) &
     ~(($past(wr_en) && $past(wr_addr) == 3'd4) ? $past(wr_data[2:0]) : 3'b000)) == 3'b000);

  // R6
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[2]) |-> $past(count_o) == {CW{1'b1}});

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> count_o == $past(wr_data));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'd0 && !(wr_en && wr_addr == 3'd0)) |=> $stable(count_o));

  // R9
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |=> !pwm_o);
endmodule

bind tmr8_cmp tmr8_cmp_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count_o(count_o), .flag_o(flag_o), .pwm_o(pwm_o), .mode_q(mode_q), .sel_q(sel_q)
);

// File: tb/tmr8_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_cmp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_o;
  logic [2:0] flag_o;
  logic       pwm_o;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr8_cmp dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .count_o(count_o), .flag_o(flag_o), .pwm_o(pwm_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic until_cnt(input logic [7:0] v);
    while (count_o != v) @(negedge clk);
  endtask

  task automatic prep(input logic [1:0] mode, input logic [7:0] ca, input logic [7:0] cb, input logic [7:0] c);
    wr(3, {4'd0, 2'd0, mode});
    wr(1, ca); wr(2, cb); wr(0, c); wr(4, 8'h07);
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 0);
    chk("R1 flags", flag_o, 0);
    chk("R1 pwm", pwm_o, 0);
  endtask

  task automatic t_normal;
    prep(2'd0, 8'h10, 8'hFE, 8'hFC);
    wr(3, 8'b0100);
    edges(3);
    chk("R4 count", count_o, 8'hFF);
    chk("R4 flagB", flag_o, 3'b010);
    edges(1);
    chk("R3 wrap", count_o, 0);
    chk("R3 ovf", flag_o, 3'b110);
  endtask

  task automatic t_suppress;
    prep(2'd0, 8'h00, 8'h20, 8'h20);
    wr(3, 8'b0100);
    edges(1);
    chk("R8 count", count_o, 8'h21);
    chk("R8 masked", flag_o, 0);
  endtask

  task automatic t_ctc;
    prep(2'd1, 8'h03, 8'h80, 8'h00);
    wr(3, 8'b0101);
    edges(4);
    chk("R5 clear", count_o, 0);
    chk("R5 flagA", flag_o, 3'b001);
    edges(4);
    chk("R5 period", count_o, 0);
    chk("R5 no ovf", flag_o, 3'b001);
  endtask

  task automatic t_ctc_wrap;
    prep(2'd1, 8'h02, 8'h80, 8'hFE);
    wr(3, 8'b0101);
    wr(4, 8'h04);
    chk("R6 wrap", count_o, 0);
    chk("R7 set wins", flag_o, 3'b100);
    wr(4, 8'h04);
    chk("R7 w1c", flag_o, 0);
  endtask

  task automatic t_presc;
    prep(2'd0, 8'h00, 8'h00, 8'h40);
    edges(20);
    chk("R2 stopped", count_o, 8'h40);
    wr(3, 8'b1000);
    edges(7);
    chk("R2 div8 early", count_o, 8'h40);
    edges(1);
    chk("R2 div8 tick", count_o, 8'h41);
    wr(3, 8'b1100);
    edges(63);
    chk("R2 div64 early", count_o, 8'h41);
    edges(1);
    chk("R2 div64 tick", count_o, 8'h42);
  endtask

  task automatic t_pwm_max;
    prep(2'd0, 8'h00, 8'h02, 8'hFE);
    wr(3, 8'b0110);
    edges(2);
    chk("R9 rise", pwm_o, 1);
    edges(2);
    chk("R9 high at match", pwm_o, 1);
    edges(1);
    chk("R9 fall", pwm_o, 0);
    wr(4, 8'h07);
    wr(2, 8'h80);
    until_cnt(8'h90);
    chk("R10 old value", flag_o[1], 0);
    until_cnt(8'h00);
    chk("R9 period start", pwm_o, 1);
    until_cnt(8'h80);
    chk("R10 before new match", pwm_o, 1);
    edges(1);
    chk("R10 new value fall", pwm_o, 0);
    chk("R4 pwm flagB", flag_o[1], 1);
  endtask

  task automatic t_pwm_a;
    prep(2'd0, 8'h04, 8'h01, 8'h00);
    wr(3, 8'b0111);
    edges(5);
    chk("R11 clear", count_o, 0);
    chk("R11 pwm high", pwm_o, 1);
    chk("R11 flags", flag_o, 3'b011);
    edges(2);
    chk("R11 fall", pwm_o, 0);
    chk("R11 count", count_o, 2);
    wr(3, 8'b0000);
    edges(1);
    chk("R9 idle low", pwm_o, 0);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset;
    t_normal;
    t_suppress;
    t_ctc;
    t_ctc_wrap;
    t_presc;
    t_pwm_max;
    t_pwm_a;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule